// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block holds three byte-wide configuration registers behind a minimal register bus. The bus has an address, a write enable with write data, and a read strobe with byte-wide read data. There is a lock control register, a read-only capability register and a clocking register. The capability register is loaded from a strap input during reset. The clocking register carries a 3-bit memory-frequency select field, and the capability code decides which select values a write may place there. A write carrying a value the capability does not allow leaves the field as it was.

Firmware sets up the clocking register and then sets the lock-down pair in the lock control register. After that, the clocking register and the lock control register both ignore bus writes until the next reset. The lock control register also holds a 3-bit write-once field, which only the first accepted write can load.

A three-state machine tracks the lock control register:
- `ST_OPEN` is the state after reset. It is unlocked and the write-once field is still unused.
- `ST_OPEN_WO` is unlocked with the write-once field already consumed.
- `ST_LOCKED` is locked down.

Transitions happen only on an accepted write to the lock control register, which is one where bit 0 equals bit 3:
- `T_SEAL` goes from `ST_OPEN` to `ST_OPEN_WO` when the lock bit is 0.
- `T_LOCK_FRESH` goes from `ST_OPEN` to `ST_LOCKED` when the lock bit is 1.
- `T_LOCK` goes from `ST_OPEN_WO` to `ST_LOCKED` when the lock bit is 1.
- `T_HOLD` keeps the state for every other case.
- `T_RESET` returns any state to `ST_OPEN` when reset is applied.

Top module: `cfgbank_lock`

## Requirements
- R1: After reset, the lock control register (address 0) and the clocking register (address 2) read 00h, and the read data output is 00h.
- R2: The capability register (address 1) reads the strap value sampled during reset in bits 2:0, with bits 7:3 zero. Bus writes to it have no effect, and strap changes after reset have no effect.
- R3: A write to address 0 where bit 0 differs from bit 3 is ignored as a whole, including bits 7:5, and does not use up the write-once field.
- R4: Bits 7:5 of address 0 are write-once. The first accepted write loads them, and later writes leave them unchanged.
- R5: An accepted write to address 0 with bits 0 and 3 both set locks the bank. While locked, bits 0 and 3 both read 1, and every write to address 0 is ignored until reset.
- R6: While locked, writes to address 2 leave the whole register unchanged.
- R7: Frequency-select codes in bits 6:4 of address 2 are 000 = 800, 001 = 1067 and 010 = 1333; codes 011 to 111 are never allowed. Capability code 000 or 101 allows codes 000 to 010. Capability code 110 allows codes 000 and 001. Any other capability code allows no code. A write with a disallowed code keeps bits 6:4 but still loads bits 7 and 3:0 while the bank is unlocked.
- R8: A read strobe at a clock edge places that register's current contents on the read data at that edge, so the data is valid in the following cycle. Reserved bits 4, 2 and 1 of address 0 read 0, unmapped addresses read 00h, and the read data holds its value while no strobe is given.
- R9: Reset clears the lock, the lock-mode bit and the write-once field, after which address 2 accepts allowed writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the capability strap is sampled while it is low |
| cap_strap | input | 3 | Maximum-frequency capability code to latch at reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
The frequency filter is swept over all eight strap codes against all eight select codes. This separates the two capability codes that allow everything, the one that caps at the middle grade, and the five reserved codes that allow nothing. It also shows that codes above 010 are always rejected while the other clocking bits still load.

The lock path is tried with several write patterns to the lock control register:
- mismatched lock/mode pairs, which show that a rejected write does not use up the write-once field;
- an unlocked write that seals the write-once field and then a locked write, separating `T_SEAL` followed by `T_LOCK` from the direct `T_LOCK_FRESH` path;
- attempts to clear the lock;
- a reset afterwards, which shows that only reset reopens the bank.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int CODE_W = 3;

    localparam logic [ADDR_W-1:0] A_LOCK = 4'd0;
    localparam logic [ADDR_W-1:0] A_CAP  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CLK  = 4'd2;

    // capability codes
    localparam logic [CODE_W-1:0] CAP_ALL    = 3'b000;
    localparam logic [CODE_W-1:0] CAP_UP1333 = 3'b101;
    localparam logic [CODE_W-1:0] CAP_UP1067 = 3'b110;

    // frequency-select codes
    localparam logic [CODE_W-1:0] FREQ_800  = 3'b000;
    localparam logic [CODE_W-1:0] FREQ_1067 = 3'b001;
    localparam logic [CODE_W-1:0] FREQ_1333 = 3'b010;

    // bit positions in the lock control register
    localparam int LK_BIT   = 0;
    localparam int MODE_BIT = 3;
    localparam int WO_LSB   = 5;

    // bit positions in the clocking register
    localparam int FSEL_LSB = 4;

    typedef enum logic [1:0] {
        ST_OPEN,
        ST_OPEN_WO,
        ST_LOCKED
    } lock_state_e;
endpackage

// File: rtl/cfgbank_lock_fsm.sv
module cfgbank_lock_fsm
    import cfgbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              lk_in,
    input  logic              mode_in,
    input  logic [CODE_W-1:0] wo_in,
    output logic              locked,
    output logic              wo_used,
    output logic [CODE_W-1:0] wo_bits
);
    lock_state_e state_q, state_d;
    logic        accept;
    logic        wo_load;

    // a write is accepted only with matching lock and mode bits
    assign accept = wr_en && (lk_in == mode_in);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (accept) state_d = lk_in ? ST_LOCKED : ST_OPEN_WO;
            end
            ST_OPEN_WO: begin
                if (accept && lk_in) state_d = ST_LOCKED;
            end
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        locked  = 1'b0;
        wo_used = 1'b0;
        wo_load = 1'b0;
        unique case (state_q)
            ST_OPEN:    wo_load = accept;
            ST_OPEN_WO: wo_used = 1'b1;
            ST_LOCKED: begin
                locked  = 1'b1;
                wo_used = 1'b1;
            end
            default: ;
        endcase
    end

    // write-once field storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wo_bits <= '0;
        else if (wo_load) wo_bits <= wo_in;
    end
endmodule

// File: rtl/cfgbank_freq_filter.sv
module cfgbank_freq_filter
    import cfgbank_pkg::*;
(
    input  logic [CODE_W-1:0] cap_code,
    input  logic [CODE_W-1:0] req_code,
    output logic              allowed
);
    always_comb begin
        unique case (cap_code)
            CAP_ALL, CAP_UP1333: allowed = (req_code <= FREQ_1333);
            CAP_UP1067:          allowed = (req_code <= FREQ_1067);
            default:             allowed = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfgbank_readmux.sv
module cfgbank_readmux
    import cfgbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] lock_view,
    input  logic [DATA_W-1:0] cap_view,
    input  logic [DATA_W-1:0] clk_view,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sel;

    always_comb begin
        unique case (addr)
            A_LOCK:  sel = lock_view;
            A_CAP:   sel = cap_view;
            A_CLK:   sel = clk_view;
            default: sel = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= sel;
    end
endmodule

// File: rtl/cfgbank_lock.sv
module cfgbank_lock
    import cfgbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] cap_strap,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int MISC_W = DATA_W - CODE_W;

    logic              wr_lock, wr_clk;
    logic              locked, wo_used, freq_ok;
    logic [CODE_W-1:0] wo_bits;
    logic [CODE_W-1:0] cap_q;
    logic [CODE_W-1:0] freq_q;
    logic [MISC_W-1:0] misc_q;
    logic [CODE_W-1:0] fsel_in;
    logic [MISC_W-1:0] misc_in;
    logic [DATA_W-1:0] lock_view, cap_view, clk_view;

    assign wr_lock = bus_wr && (bus_addr == A_LOCK);
    assign wr_clk  = bus_wr && (bus_addr == A_CLK) && !locked;

    assign fsel_in = bus_wdata[FSEL_LSB +: CODE_W];
    assign misc_in = {bus_wdata[DATA_W-1:FSEL_LSB+CODE_W], bus_wdata[FSEL_LSB-1:0]};

    cfgbank_lock_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_lock),
        .lk_in   (bus_wdata[LK_BIT]),
        .mode_in (bus_wdata[MODE_BIT]),
        .wo_in   (bus_wdata[WO_LSB +: CODE_W]),
        .locked  (locked),
        .wo_used (wo_used),
        .wo_bits (wo_bits)
    );

    cfgbank_freq_filter u_filt (
        .cap_code (cap_q),
        .req_code (fsel_in),
        .allowed  (freq_ok)
    );

    // capability latch: follows the strap only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= cap_strap;
    end

    // clocking register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_q <= '0;
            misc_q <= '0;
        end else if (wr_clk) begin
            misc_q <= misc_in;
            if (freq_ok) freq_q <= fsel_in;
        end
    end

    always_comb begin
        lock_view                       = '0;
        lock_view[WO_LSB +: CODE_W]     = wo_bits;
        lock_view[MODE_BIT]             = locked;
        lock_view[LK_BIT]               = locked;
        cap_view                        = '0;
        cap_view[CODE_W-1:0]            = cap_q;
        clk_view = {misc_q[MISC_W-1:FSEL_LSB], freq_q, misc_q[FSEL_LSB-1:0]};
    end

    cfgbank_readmux u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd),
        .addr      (bus_addr),
        .lock_view (lock_view),
        .cap_view  (cap_view),
        .clk_view  (clk_view),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/cfgbank_lock_chk.sv
module cfgbank_lock_chk
    import cfgbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              locked,
    input logic              wo_used,
    input logic              freq_ok,
    input logic [CODE_W-1:0] wo_bits,
    input logic [CODE_W-1:0] cap_q,
    input logic [CODE_W-1:0] freq_q,
    input logic [DATA_W-CODE_W-1:0] misc_q
);
    a_r2_cap_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(cap_q));

    a_r4_wo_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        wo_used |=> $stable(wo_bits));

    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    a_r6_clk_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(freq_q) && $stable(misc_q)));

    a_r7_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CLK && !freq_ok) |=> $stable(freq_q));

    a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_LOCK) |=> (bus_rdata[4] == 1'b0 && bus_rdata[2:1] == 2'b00));
endmodule

bind cfgbank_lock cfgbank_lock_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .locked    (locked),
    .wo_used   (wo_used),
    .freq_ok   (freq_ok),
    .wo_bits   (wo_bits),
    .cap_q     (cap_q),
    .freq_q    (freq_q),
    .misc_q    (misc_q)
);

// File: tb/tb_cfgbank_lock.sv
module tb_cfgbank_lock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cap_strap = 3'd0;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cfgbank_lock dut (
        .clk(clk), .rst_n(rst_n), .cap_strap(cap_strap), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] s);
        @(negedge clk);
        rst_n = 1'b0; cap_strap = s; bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic bit allowed(input logic [2:0] cap, input logic [2:0] v);
        int lim;
        lim = (cap == 3'b000 || cap == 3'b101) ? 2 : (cap == 3'b110) ? 1 : -1;
        return int'(v) <= lim;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [2:0] ef;
        logic [7:0] em;

        // R1: reset state
        do_reset(3'd0);
        @(negedge clk);
        chk("R1 rdata after reset", bus_rdata, 8'h00);
        rd(4'd0, d); chk("R1 lock reg reset", d, 8'h00);
        rd(4'd2, d); chk("R1 clk reg reset", d, 8'h00);

        // R2, R7: sweep every capability code against every select code
        for (int s = 0; s < 8; s++) begin
            do_reset(3'(s));
            rd(4'd1, d); chk("R2 cap strap", d, 8'(s));
            wr(4'd1, 8'hFF);
            cap_strap = ~3'(s);
            rd(4'd1, d); chk("R2 cap unaffected", d, 8'(s));
            ef = 3'd0;
            for (int v = 0; v < 8; v++) begin
                em = {1'(v), 3'b000, 4'(v ^ 5)};
                wr(4'd2, em | 8'(v << 4));
                if (allowed(3'(s), 3'(v))) ef = 3'(v);
                rd(4'd2, d); chk("R7 freq filter", d, em | {1'b0, ef, 4'b0000});
            end
        end

        // R8: unmapped addresses, hold without strobe, reserved bits
        do_reset(3'd0);
        rd(4'd5, d);  chk("R8 unmapped 5", d, 8'h00);
        wr(4'd2, 8'h9A);
        rd(4'd2, d);  chk("R8 read clk", d, 8'h9A);
        repeat (3) @(negedge clk);
        chk("R8 rdata holds", bus_rdata, 8'h9A);
        rd(4'd15, d); chk("R8 unmapped 15", d, 8'h00);
        wr(4'd0, 8'h16);
        rd(4'd0, d);  chk("R8 reserved bits zero", d, 8'h00);

        // R3, R4, R5, R6: T_SEAL then T_LOCK path
        do_reset(3'd0);
        wr(4'd0, 8'h01); rd(4'd0, d); chk("R3 mismatch 01 ignored", d, 8'h00);
        wr(4'd0, 8'h08); rd(4'd0, d); chk("R3 mismatch 08 ignored", d, 8'h00);
        wr(4'd0, 8'hE1); rd(4'd0, d); chk("R3 mismatch keeps wo unused", d, 8'h00);
        wr(4'd0, 8'hA0); rd(4'd0, d); chk("R4 first write loads", d, 8'hA0);
        wr(4'd0, 8'h40); rd(4'd0, d); chk("R4 second write ignored", d, 8'hA0);
        wr(4'd2, 8'h25); rd(4'd2, d); chk("R6 unlocked write", d, 8'h25);
        wr(4'd0, 8'hF9); rd(4'd0, d); chk("R5 lock set", d, 8'hA9);
        wr(4'd0, 8'h00); rd(4'd0, d); chk("R5 clear ignored", d, 8'hA9);
        wr(4'd0, 8'h08); rd(4'd0, d); chk("R5 mismatch while locked", d, 8'hA9);
        wr(4'd2, 8'h1F); rd(4'd2, d); chk("R6 locked write ignored", d, 8'h25);

        // R9: reset reopens
        do_reset(3'd0);
        rd(4'd0, d); chk("R9 lock cleared", d, 8'h00);
        wr(4'd2, 8'h11); rd(4'd2, d); chk("R9 clk writable", d, 8'h11);

        // R5: T_LOCK_FRESH path
        wr(4'd0, 8'h69); rd(4'd0, d); chk("R5 direct lock", d, 8'h69);
        wr(4'd0, 8'hE9); rd(4'd0, d); chk("R5 wo kept when locked", d, 8'h69);
        wr(4'd2, 8'h00); rd(4'd2, d); chk("R6 frozen after direct lock", d, 8'h11);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule